// File: doc/BRIEF.md
# Dual-Timebase Sweep Gate Controller

This block is the digital sequencer behind a two-timebase scope sweep. It waits out a holdoff and then arms. On the next rising edge of the main trigger it opens the main sweep gate. The main gate stays open until the analog ramp reports its end. While the main sweep runs, a match from an external delay comparator opens the delayed sweep gate. That happens either at once or on the next rising edge of the delayed trigger. The delayed gate closes at its own end-of-sweep signal, or earlier if the main sweep ends first.

From the selected view the block derives two intensity controls. One brightens the part of the main trace covered by the delayed sweep. The other blanks the trace outside the delayed gate. In the alternating view, successive main sweeps switch between these two presentations. The settings come in as one parallel word that a serial-to-parallel converter holds. Seven gate and status lines leave the block as one vector.

An auto-set helper counts main-trigger edges inside each main sweep. When the sweep closes it reports the count with a one-cycle strobe. It also flags whether the count reached the minimum number of periods that auto-set aims for.

Top module: `sweep_gate_ctrl`

## Requirements
- R1: While reset is held, `gate_vec` equals 7'b0010000 (only the holdoff bit set), `trig_count` is 0, and `cnt_valid` and `auto_ok` are 0.
- R2: When armed (`gate_vec[5]`), a rising edge of `trig_main` at a clock edge sets `gate_vec[0]` (main gate) after that edge. Edges that occur during holdoff, and that have ended before arming, never open the gate.
- R3: A `main_end` seen while the main gate is open clears `gate_vec[0]` and sets `gate_vec[4]` (holdoff) at the same edge. Holdoff then lasts `cfg_word[HO_W+2:3]`+1 cycles, after which `gate_vec[5]` is set.
- R4: With `cfg_word[2]`=0, a `dly_match` seen while the main gate is open sets `gate_vec[1]` (delayed gate) after that edge.
- R5: With `cfg_word[2]`=1, `dly_match` opens nothing by itself. The delayed gate opens after the first rising edge of `trig_dly` in a later cycle.
- R6: The delayed gate is only open while the main gate is open. It closes at `dly_end` or at `main_end`, whichever comes first, and opens at most once per main sweep.
- R7: The view is `cfg_word[1:0]`: 0 main only, 1 intensified, 2 delayed, 3 alternate. In the intensified view `gate_vec[2]` (Z1) equals the delayed gate and Z2 is 0. In the delayed view `gate_vec[3]` (Z2) is 1 whenever the delayed gate is closed and Z1 is 0. In the main-only view both are 0.
- R8: In the alternate view, `gate_vec[6]` toggles at each main-sweep close and is 0 in the other views. With it at 0, Z1/Z2 behave as in the intensified view; with it at 1, they behave as in the delayed view.
- R9: The counter clears when the main gate opens. It adds one for each `trig_main` rising edge while the gate is open, except at the closing edge, and saturates at 2^CNT_W-1. On close, `trig_count` takes the count and `cnt_valid` pulses for one cycle. `auto_ok` is 1 when the count is at least MIN_PERIODS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_word | input | HO_W+3 | Settings: [1:0] view, [2] delayed start mode, [HO_W+2:3] holdoff length |
| trig_main | input | 1 | Main trigger level (synchronous) |
| trig_dly | input | 1 | Delayed-timebase trigger level (synchronous) |
| dly_match | input | 1 | Match from the external delay comparator |
| dly_end | input | 1 | End of the delayed ramp |
| main_end | input | 1 | End of the main ramp |
| gate_vec | output | 7 | [0] main gate, [1] delayed gate, [2] Z1 intensify, [3] Z2 blank, [4] holdoff, [5] armed, [6] alternate pass |
| trig_count | output | CNT_W | Trigger count latched at the last main-sweep close |
| cnt_valid | output | 1 | One-cycle strobe when a new count is latched |
| auto_ok | output | 1 | Latched count is at least MIN_PERIODS |

## Verification
The main sweep is driven with trigger bursts of different lengths. A burst of two edges sits under the period target and a burst of three sits exactly on it; these tell the threshold apart. A burst far beyond the counter range separates saturation from wrap-around. A trigger pulse placed inside holdoff shows whether edges are latched early or ignored. The delayed sweep is tried in both start modes and in all four views. The sequences are arranged so that a match without a trigger, a second match after `dly_end`, and a `main_end` cutting an open delayed sweep each give a different gate and intensity outcome.

// File: rtl/sgc_pkg.sv
package sgc_pkg;
   typedef enum logic [1:0] {MS_HOLD = 2'd0, MS_ARMED = 2'd1, MS_SWEEP = 2'd2} main_st_t;
   typedef enum logic [1:0] {DS_IDLE = 2'd0, DS_WAIT = 2'd1, DS_RUN = 2'd2, DS_DONE = 2'd3} dly_st_t;
   typedef enum logic [1:0] {VW_MAIN = 2'd0, VW_INTEN = 2'd1, VW_DELAY = 2'd2, VW_ALT = 2'd3} view_t;

   // bit positions inside the gate vector
   localparam int GB_MAIN  = 0;
   localparam int GB_DLY   = 1;
   localparam int GB_Z1    = 2;
   localparam int GB_Z2    = 3;
   localparam int GB_HOLD  = 4;
   localparam int GB_ARMED = 5;
   localparam int GB_ALT   = 6;
   localparam int GB_COUNT = 7;

   // settings word layout
   localparam int CF_VIEW_LSB = 0;
   localparam int CF_MODE     = 2;
   localparam int CF_HO_LSB   = 3;
endpackage

// File: rtl/sgc_edge.sv
module sgc_edge #(
   parameter int N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] lvl,
   output logic [N-1:0] rise
);
   for (genvar i = 0; i < N; i++) begin : g_bit
      logic prev;
      always_ff @(posedge clk) begin
         if (!rst_n) prev <= 1'b0;
         else        prev <= lvl[i];
      end
      assign rise[i] = lvl[i] & ~prev;
   end
endmodule

// File: rtl/sgc_main_fsm.sv
module sgc_main_fsm
   import sgc_pkg::*;
#(
   parameter int HO_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            trig_rise,
   input  logic            main_end,
   input  logic [HO_W-1:0] holdoff,
   output main_st_t        st,
   output logic            open_evt,
   output logic            close_evt
);
   logic [HO_W-1:0] hcnt;
   main_st_t        nxt;

   always_comb begin
      nxt       = st;
      open_evt  = 1'b0;
      close_evt = 1'b0;
      case (st)
         MS_HOLD:  if (hcnt >= holdoff) nxt = MS_ARMED;
         MS_ARMED: if (trig_rise) begin
            nxt      = MS_SWEEP;
            open_evt = 1'b1;
         end
         MS_SWEEP: if (main_end) begin
            nxt       = MS_HOLD;
            close_evt = 1'b1;
         end
         default:  nxt = MS_HOLD;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st   <= MS_HOLD;
         hcnt <= '0;
      end else begin
         st <= nxt;
         if (close_evt)          hcnt <= '0;
         else if (st == MS_HOLD) hcnt <= hcnt + 1'b1;
      end
   end
endmodule

// File: rtl/sgc_dly_fsm.sv
module sgc_dly_fsm
   import sgc_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    in_sweep,
   input  logic    close_evt,
   input  logic    match,
   input  logic    trig_rise,
   input  logic    dly_end,
   input  logic    trig_mode,
   output dly_st_t st
);
   dly_st_t nxt;

   always_comb begin
      nxt = st;
      if (!in_sweep || close_evt) begin
         nxt = DS_IDLE;
      end else begin
         case (st)
            DS_IDLE: if (match)     nxt = trig_mode ? DS_WAIT : DS_RUN;
            DS_WAIT: if (trig_rise) nxt = DS_RUN;
            DS_RUN:  if (dly_end)   nxt = DS_DONE;
            default: nxt = st;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) st <= DS_IDLE;
      else        st <= nxt;
   end
endmodule

// File: rtl/sgc_trig_count.sv
module sgc_trig_count #(
   parameter int CNT_W   = 6,
   parameter int MIN_PER = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             open_evt,
   input  logic             close_evt,
   input  logic             in_sweep,
   input  logic             trig_rise,
   output logic [CNT_W-1:0] count,
   output logic             valid,
   output logic             enough
);
   localparam logic [CNT_W-1:0] CMAX = '1;
   localparam logic [CNT_W-1:0] CMIN = CNT_W'(MIN_PER);

   logic [CNT_W-1:0] run;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run    <= '0;
         count  <= '0;
         valid  <= 1'b0;
         enough <= 1'b0;
      end else begin
         valid <= close_evt;
         if (open_evt)
            run <= '0;
         else if (in_sweep && trig_rise && run != CMAX)
            run <= run + 1'b1;
         if (close_evt) begin
            count  <= run;
            enough <= (run >= CMIN);
         end
      end
   end
endmodule

// File: rtl/sweep_gate_ctrl.sv
module sweep_gate_ctrl
   import sgc_pkg::*;
#(
   parameter int HO_W        = 8,
   parameter int CNT_W       = 6,
   parameter int MIN_PERIODS = 3,
   localparam int CFG_W      = HO_W + 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [CFG_W-1:0]    cfg_word,
   input  logic                trig_main,
   input  logic                trig_dly,
   input  logic                dly_match,
   input  logic                dly_end,
   input  logic                main_end,
   output logic [GB_COUNT-1:0] gate_vec,
   output logic [CNT_W-1:0]    trig_count,
   output logic                cnt_valid,
   output logic                auto_ok
);
   initial begin
      if (HO_W < 1)  $error("HO_W must be at least 1");
      if (CNT_W < 2) $error("CNT_W must be at least 2");
      if (MIN_PERIODS < 1 || MIN_PERIODS > (2 ** CNT_W) - 1)
         $error("MIN_PERIODS out of counter range");
   end

   view_t     view;
   logic      trig_mode;
   logic [HO_W-1:0] holdoff;
   logic [1:0] rises;
   main_st_t  mst;
   dly_st_t   dst;
   logic      open_evt, close_evt, in_sweep, dly_open;
   logic      alt_phase, show_inten, show_delay;

   assign view      = view_t'(cfg_word[CF_VIEW_LSB +: 2]);
   assign trig_mode = cfg_word[CF_MODE];
   assign holdoff   = cfg_word[CF_HO_LSB +: HO_W];

   sgc_edge #(.N(2)) u_edge (
      .clk(clk), .rst_n(rst_n), .lvl({trig_dly, trig_main}), .rise(rises)
   );

   sgc_main_fsm #(.HO_W(HO_W)) u_main (
      .clk(clk), .rst_n(rst_n), .trig_rise(rises[0]), .main_end(main_end),
      .holdoff(holdoff), .st(mst), .open_evt(open_evt), .close_evt(close_evt)
   );

   assign in_sweep = (mst == MS_SWEEP);

   sgc_dly_fsm u_dly (
      .clk(clk), .rst_n(rst_n), .in_sweep(in_sweep), .close_evt(close_evt),
      .match(dly_match), .trig_rise(rises[1]), .dly_end(dly_end),
      .trig_mode(trig_mode), .st(dst)
   );

   assign dly_open = (dst == DS_RUN);

   sgc_trig_count #(.CNT_W(CNT_W), .MIN_PER(MIN_PERIODS)) u_cnt (
      .clk(clk), .rst_n(rst_n), .open_evt(open_evt), .close_evt(close_evt),
      .in_sweep(in_sweep), .trig_rise(rises[0]), .count(trig_count),
      .valid(cnt_valid), .enough(auto_ok)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)              alt_phase <= 1'b0;
      else if (view != VW_ALT) alt_phase <= 1'b0;
      else if (close_evt)      alt_phase <= ~alt_phase;
   end

   assign show_inten = (view == VW_INTEN) || (view == VW_ALT && !alt_phase);
   assign show_delay = (view == VW_DELAY) || (view == VW_ALT && alt_phase);

   always_comb begin
      gate_vec           = '0;
      gate_vec[GB_MAIN]  = in_sweep;
      gate_vec[GB_DLY]   = dly_open;
      gate_vec[GB_Z1]    = show_inten & dly_open;
      gate_vec[GB_Z2]    = show_delay & ~dly_open;
      gate_vec[GB_HOLD]  = (mst == MS_HOLD);
      gate_vec[GB_ARMED] = (mst == MS_ARMED);
      gate_vec[GB_ALT]   = alt_phase;
   end
endmodule

// File: rtl/sgc_checker.sv
module sgc_checker
   import sgc_pkg::*;
(
   input logic                clk,
   input logic                rst_n,
   input logic                trig_main,
   input logic                main_end,
   input logic                dly_end,
   input logic [GB_COUNT-1:0] gate_vec,
   input logic                cnt_valid
);
   a_r2_open_on_trigger: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_vec[GB_ARMED] && trig_main && !$past(trig_main)) |=> gate_vec[GB_MAIN]);

   a_r3_close_to_holdoff: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_vec[GB_MAIN] && main_end) |=> (!gate_vec[GB_MAIN] && gate_vec[GB_HOLD]));

   a_r3_hold_blocks_open: assert property (@(posedge clk) disable iff (!rst_n)
      gate_vec[GB_HOLD] |=> !gate_vec[GB_MAIN]);

   a_r6_dly_inside_main: assert property (@(posedge clk) disable iff (!rst_n)
      gate_vec[GB_DLY] |-> gate_vec[GB_MAIN]);

   a_r6_dly_end_closes: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_vec[GB_DLY] && dly_end) |=> !gate_vec[GB_DLY]);

   a_r7_z_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(gate_vec[GB_Z1] && gate_vec[GB_Z2]));

   a_r9_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_valid |=> !cnt_valid);

   a_r9_valid_on_close: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(gate_vec[GB_MAIN]) |-> cnt_valid);
endmodule

bind sweep_gate_ctrl sgc_checker u_sgc_checker (
   .clk(clk), .rst_n(rst_n), .trig_main(trig_main), .main_end(main_end),
   .dly_end(dly_end), .gate_vec(gate_vec), .cnt_valid(cnt_valid)
);

// File: tb/sweep_gate_ctrl_bench.sv
module sweep_gate_ctrl_bench;
   import sgc_pkg::*;

   localparam int HO_W  = 8;
   localparam int CNT_W = 6;
   localparam int MINP  = 3;
   localparam int CFG_W = HO_W + 3;
   localparam int CMAX  = (2 ** CNT_W) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [CFG_W-1:0] cfg_word = '0;
   logic trig_main = 1'b0, trig_dly = 1'b0, dly_match = 1'b0, dly_end = 1'b0, main_end = 1'b0;
   logic [GB_COUNT-1:0] gate_vec;
   logic [CNT_W-1:0] trig_count;
   logic cnt_valid, auto_ok;

   int total = 0;
   int bad = 0;
   int exp_q[$];
   bit finished = 1'b0;

   always #10 clk = ~clk;

   sweep_gate_ctrl #(.HO_W(HO_W), .CNT_W(CNT_W), .MIN_PERIODS(MINP)) u_sweep_gate_ctrl (
      .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .trig_main(trig_main),
      .trig_dly(trig_dly), .dly_match(dly_match), .dly_end(dly_end),
      .main_end(main_end), .gate_vec(gate_vec), .trig_count(trig_count),
      .cnt_valid(cnt_valid), .auto_ok(auto_ok)
   );

   task automatic check(string req, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic set_cfg(int view, int mode, int ho);
      cfg_word = {HO_W'(ho), mode[0], view[1:0]};
   endtask

   task automatic pulse_main();
      trig_main = 1'b1; tick(); trig_main = 1'b0;
   endtask

   task automatic pulse_match();
      dly_match = 1'b1; tick(); dly_match = 1'b0;
   endtask

   task automatic wait_armed();
      for (int n = 0; n < 2000 && !gate_vec[GB_ARMED]; n++) tick();
   endtask

   // driver side of the scoreboard: predicted count for this sweep
   task automatic end_main(int edges);
      exp_q.push_back(edges > CMAX ? CMAX : edges);
      main_end = 1'b1; tick(); main_end = 1'b0;
   endtask

   task automatic finish_run();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   // monitor side of the scoreboard
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && cnt_valid) begin
            if (exp_q.size() == 0) begin
               check("R9 strobe without sweep", 1, 0);
            end else begin
               int e;
               e = exp_q.pop_front();
               check("R9 latched count", int'(trig_count), e);
               check("R9 period flag", int'(auto_ok), (e >= MINP) ? 1 : 0);
            end
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         check("watchdog expired", 1, 0);
         finish_run();
      end
   end

   initial begin
      int n;
      set_cfg(0, 0, 3);
      repeat (3) tick();
      // R1 reset state
      check("R1 gate vector in reset", int'(gate_vec), 16);
      check("R1 count in reset", int'(trig_count), 0);
      check("R1 strobe in reset", int'(cnt_valid), 0);
      check("R1 flag in reset", int'(auto_ok), 0);
      rst_n = 1'b1;

      // R3 holdoff length after reset
      n = 0;
      while (gate_vec[GB_HOLD] && n < 100) begin n++; tick(); end
      check("R3 holdoff cycles after reset", n, 4);
      check("R3 armed after holdoff", int'(gate_vec[GB_ARMED]), 1);

      // R2 open, R9 five edges
      pulse_main();
      check("R2 main gate opens", int'(gate_vec[GB_MAIN]), 1);
      for (int i = 0; i < 5; i++) begin tick(); pulse_main(); end
      tick();
      end_main(5);
      check("R3 gate closes on end", int'(gate_vec[GB_MAIN]), 0);
      check("R3 holdoff entered", int'(gate_vec[GB_HOLD]), 1);
      n = 0;
      while (gate_vec[GB_HOLD] && n < 100) begin n++; tick(); end
      check("R3 holdoff cycles after sweep", n, 4);

      // R2 trigger during holdoff ignored; R9 two edges under target
      wait_armed();
      pulse_main();
      tick(); pulse_main(); tick(); pulse_main(); tick();
      set_cfg(0, 0, 10);
      end_main(2);
      pulse_main();
      tick();
      wait_armed();
      check("R2 holdoff trigger ignored", int'(gate_vec[GB_MAIN]), 0);
      repeat (3) tick();
      check("R2 still closed without edge", int'(gate_vec[GB_MAIN]), 0);

      // R4 start-after-delay, intensified view
      set_cfg(1, 0, 3);
      pulse_main();
      check("R4 delayed gate idle before match", int'(gate_vec[GB_DLY]), 0);
      check("R7 no intensify before match", int'(gate_vec[GB_Z1]), 0);
      pulse_match();
      check("R4 delayed gate opens on match", int'(gate_vec[GB_DLY]), 1);
      check("R7 intensify during delayed gate", int'(gate_vec[GB_Z1]), 1);
      check("R7 no blank in intensified view", int'(gate_vec[GB_Z2]), 0);
      tick();
      dly_end = 1'b1; tick(); dly_end = 1'b0;
      check("R6 dly_end closes delayed gate", int'(gate_vec[GB_DLY]), 0);
      check("R7 intensify off after close", int'(gate_vec[GB_Z1]), 0);
      pulse_match();
      check("R6 no second delayed sweep", int'(gate_vec[GB_DLY]), 0);
      tick();
      end_main(0);

      // R5 triggered start, delayed view
      set_cfg(2, 1, 3);
      wait_armed();
      pulse_main();
      check("R7 blank outside delayed gate", int'(gate_vec[GB_Z2]), 1);
      pulse_match();
      check("R5 match alone does not open", int'(gate_vec[GB_DLY]), 0);
      tick();
      trig_dly = 1'b1; tick(); trig_dly = 1'b0;
      check("R5 delayed trigger opens gate", int'(gate_vec[GB_DLY]), 1);
      check("R7 unblank inside delayed gate", int'(gate_vec[GB_Z2]), 0);
      check("R7 no intensify in delayed view", int'(gate_vec[GB_Z1]), 0);
      tick();
      end_main(0);
      check("R6 main_end closes delayed gate", int'(gate_vec[GB_DLY]), 0);
      check("R6 main gate closed too", int'(gate_vec[GB_MAIN]), 0);

      // R8 alternate view
      set_cfg(3, 0, 3);
      tick();
      check("R8 phase starts at main pass", int'(gate_vec[GB_ALT]), 0);
      wait_armed();
      pulse_main();
      pulse_match();
      check("R8 main pass intensifies", int'(gate_vec[GB_Z1]), 1);
      check("R8 main pass no blank", int'(gate_vec[GB_Z2]), 0);
      tick();
      end_main(0);
      check("R8 phase toggles to delayed pass", int'(gate_vec[GB_ALT]), 1);
      wait_armed();
      pulse_main();
      check("R8 delayed pass blanks", int'(gate_vec[GB_Z2]), 1);
      pulse_match();
      check("R8 delayed pass unblanks in gate", int'(gate_vec[GB_Z2]), 0);
      check("R8 delayed pass no intensify", int'(gate_vec[GB_Z1]), 0);
      tick();
      end_main(0);
      check("R8 phase back to main pass", int'(gate_vec[GB_ALT]), 0);

      // R9 saturation
      set_cfg(0, 0, 3);
      wait_armed();
      pulse_main();
      for (int i = 0; i < CMAX + 7; i++) begin tick(); pulse_main(); end
      tick();
      end_main(CMAX + 7);

      // R9 clear on open and threshold boundary
      wait_armed();
      pulse_main();
      for (int i = 0; i < MINP; i++) begin tick(); pulse_main(); end
      tick();
      end_main(MINP);

      repeat (4) tick();
      check("R9 every sweep reported", exp_q.size(), 0);
      finished = 1'b1;
      finish_run();
   end
endmodule